// File: doc/BRIEF.md
# Stretchable External Memory Cycle Sequencer

This block runs single read and write accesses to an external data memory. The length of each access is set by a 3-bit stretch value held in a small control register. A requester raises a start pulse with a direction select, an address and (for writes) a data byte. The sequencer then drives the memory address with an address-valid strobe, together with a read strobe or a write strobe. Each strobe is held for a number of clock cycles derived from the stretch value. At the end of the access it pulses `done` and returns to idle.

Reads and writes follow different formulas. A read keeps the address valid for stretch+1 cycles and holds the read strobe over that whole window. The data is captured on the final strobe cycle. A write keeps the address valid for stretch+2 cycles. Its write strobe starts one cycle after the address and lasts stretch cycles, never fewer than one. The stretch value is sampled when a request is accepted, so writing the register in the middle of an access only affects later accesses.

The controller is a state machine with six states:
- `XS_IDLE` waits for a request.
- `XS_RD_STRB` drives the read strobe.
- `XS_WR_SETUP` gives the write address one cycle of setup.
- `XS_WR_STRB` drives the write strobe.
- `XS_WR_HOLD` holds the address for one cycle after the strobe.
- `XS_FINISH` raises `done`.

Its transitions are:
- IDLE→RD_STRB on an accepted read.
- IDLE→WR_SETUP on an accepted write.
- RD_STRB→FINISH when the read window counter expires.
- WR_SETUP→WR_STRB unconditionally.
- WR_STRB→WR_HOLD when the strobe counter expires and the stretch is nonzero.
- WR_STRB→FINISH when the strobe counter expires and the stretch is zero.
- WR_HOLD→FINISH unconditionally.
- FINISH→IDLE unconditionally.

Top module: `xmem_stretch_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `mem_addr_vld`, `mem_rd`, `mem_wr` are 0 and `rd_data` is 0. The stretch register holds 1, so a read started before any register write has a 2-cycle strobe.
- R2: When `cfg_we` is 1 at a clock edge, `cfg_stretch` (unsigned, 0 to 7) is stored as the stretch value S.
- R3: An accepted read drives `mem_addr_vld` and `mem_rd` together for exactly S+1 consecutive cycles. These start in the cycle after the accepting edge, with `mem_addr` equal to the requested address.
- R4: The read result is the `mem_rdata` value present in the last `mem_rd` cycle. It appears on `rd_data` from the `done` cycle and is unchanged until the next read completes; writes leave it untouched.
- R5: An accepted write drives `mem_addr_vld` for exactly S+2 consecutive cycles, starting in the cycle after the accepting edge. During that window `mem_addr` and `mem_wdata` equal the requested address and data.
- R6: The write strobe `mem_wr` rises in the second address-valid cycle and lasts max(S,1) cycles. For S≥1 the address stays valid for one cycle after `mem_wr` falls. For S=0 both fall together.
- R7: `done` is a one-cycle pulse in the cycle right after the last address-valid cycle. `busy` is 1 from the cycle after acceptance through the `done` cycle and 0 otherwise.
- R8: A request is accepted only when `busy` is 0. A `req_start` raised while busy has no effect: it produces no extra strobe and no extra `done`.
- R9: S is sampled at acceptance. A register write during an access leaves that access unchanged and applies from the next accepted request.
- R10: `mem_rd` and `mem_wr` are never 1 together, and neither is 1 while `mem_addr_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all widths are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Stretch register write enable |
| cfg_stretch | input | 3 | New stretch value, 0 to 7 |
| req_start | input | 1 | Request pulse, taken only when idle |
| req_write | input | 1 | 1 selects write, 0 selects read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Access in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Data captured by the last read |
| mem_addr | output | 16 | Memory address |
| mem_addr_vld | output | 1 | Address-valid strobe |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |

## Verification
The width checks assume the stretch value latched at acceptance stays steady until the block is idle again. The stimulus also respects this: it writes the register mid-access only to show that nothing changes. The assertions further assume `rst_n` is held low through the first edges, so the run-length counters start from zero.

The bench sweeps all eight stretch values for both directions. Its memory model returns data that changes on every strobe cycle, which confirms that capture happens on the final strobe cycle and not earlier. Stray requests are raised only while a long access is in progress and are dropped one cycle later.

// File: rtl/xmem_seq_pkg.sv
package xmem_seq_pkg;
    typedef enum logic [2:0] {
        XS_IDLE,
        XS_RD_STRB,
        XS_WR_SETUP,
        XS_WR_STRB,
        XS_WR_HOLD,
        XS_FINISH
    } xs_state_e;
endpackage

// File: rtl/xmem_stretch_reg.sv
module xmem_stretch_reg #(
    parameter int STRETCH_W = 3,
    parameter int RST_VAL   = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [STRETCH_W-1:0] din,
    output logic [STRETCH_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= STRETCH_W'(RST_VAL);
        end else if (we) begin
            q <= din;
        end
    end
endmodule

// File: rtl/xmem_width_calc.sv
// Derives per-access phase lengths from the latched stretch value.
module xmem_width_calc #(
    parameter int STRETCH_W = 3
) (
    input  logic [STRETCH_W-1:0] stretch,
    output logic [STRETCH_W-1:0] wr_last,   // write strobe cycles minus one
    output logic                 has_hold   // one address cycle after strobe
);
    always_comb begin
        if (stretch == '0) begin
            wr_last  = '0;
            has_hold = 1'b0;
        end else begin
            wr_last  = stretch - STRETCH_W'(1);
            has_hold = 1'b1;
        end
    end
endmodule

// File: rtl/xmem_cycle_ctr.sv
module xmem_cycle_ctr #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/xmem_stretch_seq.sv
module xmem_stretch_seq
    import xmem_seq_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int STRETCH_W   = 3,
    parameter int STRETCH_RST = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [STRETCH_W-1:0] cfg_stretch,
    input  logic                 req_start,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_W-1:0]    rd_data,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 mem_addr_vld,
    output logic                 mem_rd,
    output logic                 mem_wr,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic [DATA_W-1:0]    mem_rdata
);
    xs_state_e              state_q, state_d;
    logic [STRETCH_W-1:0]   cfg_q;
    logic [STRETCH_W-1:0]   act_stretch_q;
    logic [STRETCH_W-1:0]   wr_last;
    logic                   has_hold;
    logic                   ctr_load;
    logic [STRETCH_W-1:0]   ctr_val;
    logic                   ctr_zero;
    logic                   accept;
    logic                   capture;
    logic [ADDR_W-1:0]      addr_q;
    logic [DATA_W-1:0]      wdata_q;
    logic [DATA_W-1:0]      rdata_q;

    xmem_stretch_reg #(
        .STRETCH_W (STRETCH_W),
        .RST_VAL   (STRETCH_RST)
    ) cfg_reg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .din   (cfg_stretch),
        .q     (cfg_q)
    );

    xmem_width_calc #(
        .STRETCH_W (STRETCH_W)
    ) calc_i (
        .stretch  (act_stretch_q),
        .wr_last  (wr_last),
        .has_hold (has_hold)
    );

    xmem_cycle_ctr #(
        .CNT_W (STRETCH_W)
    ) ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (ctr_val),
        .zero     (ctr_zero)
    );

    assign accept  = (state_q == XS_IDLE) && req_start;
    assign capture = (state_q == XS_RD_STRB) && ctr_zero;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // request capture and read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_stretch_q <= STRETCH_W'(STRETCH_RST);
            addr_q        <= '0;
            wdata_q       <= '0;
            rdata_q       <= '0;
        end else begin
            if (accept) begin
                act_stretch_q <= cfg_q;
                addr_q        <= req_addr;
                wdata_q       <= req_wdata;
            end
            if (capture) begin
                rdata_q <= mem_rdata;
            end
        end
    end

    // next state and counter loading
    always_comb begin
        state_d  = state_q;
        ctr_load = 1'b0;
        ctr_val  = '0;
        unique case (state_q)
            XS_IDLE: begin
                if (req_start) begin
                    if (req_write) begin
                        state_d = XS_WR_SETUP;
                    end else begin
                        state_d  = XS_RD_STRB;
                        ctr_load = 1'b1;
                        ctr_val  = cfg_q;     // S+1 strobe cycles
                    end
                end
            end
            XS_RD_STRB: begin
                if (ctr_zero) begin
                    state_d = XS_FINISH;
                end
            end
            XS_WR_SETUP: begin
                state_d  = XS_WR_STRB;
                ctr_load = 1'b1;
                ctr_val  = wr_last;
            end
            XS_WR_STRB: begin
                if (ctr_zero) begin
                    state_d = has_hold ? XS_WR_HOLD : XS_FINISH;
                end
            end
            XS_WR_HOLD: begin
                state_d = XS_FINISH;
            end
            XS_FINISH: begin
                state_d = XS_IDLE;
            end
            default: begin
                state_d = XS_IDLE;
            end
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        busy         = 1'b1;
        done         = 1'b0;
        mem_addr_vld = 1'b0;
        mem_rd       = 1'b0;
        mem_wr       = 1'b0;
        unique case (state_q)
            XS_IDLE: begin
                busy = 1'b0;
            end
            XS_RD_STRB: begin
                mem_addr_vld = 1'b1;
                mem_rd       = 1'b1;
            end
            XS_WR_SETUP: begin
                mem_addr_vld = 1'b1;
            end
            XS_WR_STRB: begin
                mem_addr_vld = 1'b1;
                mem_wr       = 1'b1;
            end
            XS_WR_HOLD: begin
                mem_addr_vld = 1'b1;
            end
            XS_FINISH: begin
                done = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign rd_data   = rdata_q;
endmodule

// File: rtl/xmem_stretch_seq_chk.sv
module xmem_stretch_seq_chk #(
    parameter int STRETCH_W = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 busy,
    input logic                 done,
    input logic                 mem_addr_vld,
    input logic                 mem_rd,
    input logic                 mem_wr,
    input logic [STRETCH_W-1:0] act_stretch
);
    localparam int LW = STRETCH_W + 2;

    logic [LW-1:0] vld_run, rd_run, wr_run;
    logic          wr_seen;
    logic [LW-1:0] exp_rd, exp_wr_vld, exp_wr_strb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_run <= '0;
            rd_run  <= '0;
            wr_run  <= '0;
            wr_seen <= 1'b0;
        end else begin
            vld_run <= mem_addr_vld ? vld_run + LW'(1) : '0;
            rd_run  <= mem_rd ? rd_run + LW'(1) : '0;
            wr_run  <= mem_wr ? wr_run + LW'(1) : '0;
            wr_seen <= mem_addr_vld ? (wr_seen | mem_wr) : 1'b0;
        end
    end

    always_comb begin
        exp_rd      = LW'(act_stretch) + LW'(1);
        exp_wr_vld  = LW'(act_stretch) + LW'(2);
        exp_wr_strb = (act_stretch == '0) ? LW'(1) : LW'(act_stretch);
    end

    // R3
    rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rd) |-> rd_run == exp_rd);

    // R5
    wr_addr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_addr_vld) && wr_seen) |-> vld_run == exp_wr_vld);

    // R6
    wr_strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr) |-> wr_run == exp_wr_strb);

    // R6
    wr_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr) |-> $past(mem_addr_vld));

    // R7
    done_follows_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_addr_vld) |-> done);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_addr_vld && !done);

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R10
    strobe_in_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> mem_addr_vld);
endmodule

bind xmem_stretch_seq xmem_stretch_seq_chk #(
    .STRETCH_W (STRETCH_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .done         (done),
    .mem_addr_vld (mem_addr_vld),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr),
    .act_stretch  (act_stretch_q)
);

// File: tb/xmem_stretch_seq_tb_top.sv
`timescale 1ns/1ps
module xmem_stretch_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_stretch;
    logic        req_start;
    logic        req_write;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic        busy, done, mem_addr_vld, mem_rd, mem_wr;
    logic [7:0]  rd_data, mem_wdata, mem_rdata;
    logic [15:0] mem_addr;
    logic [7:0]  rd_cnt = 8'd0;
    logic [7:0]  last_rd = 8'd0;

    int  n_chk = 0;
    int  n_err = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    xmem_stretch_seq dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_stretch  (cfg_stretch),
        .req_start    (req_start),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .busy         (busy),
        .done         (done),
        .rd_data      (rd_data),
        .mem_addr     (mem_addr),
        .mem_addr_vld (mem_addr_vld),
        .mem_rd       (mem_rd),
        .mem_wr       (mem_wr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata)
    );

    function automatic logic [7:0] model(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    // memory model: data changes on every strobe cycle
    always @(posedge clk) begin
        if (mem_rd) rd_cnt <= rd_cnt + 8'd1;
        else        rd_cnt <= 8'd0;
    end
    assign mem_rdata = model(mem_addr) ^ rd_cnt;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cfg_write(input int v);
        @(negedge clk);
        cfg_we      = 1'b1;
        cfg_stretch = v[2:0];
        @(negedge clk);
        cfg_we      = 1'b0;
    endtask

    // wr: direction, s: stretch expected for this access,
    // inj_cfg >= 0: register write during the access, inj_req: stray request
    task automatic run_access(input bit wr, input logic [15:0] a, input logic [7:0] d,
                              input int s, input int inj_cfg, input bit inj_req);
        int   wl;
        int   last;
        logic [4:0] act_v, exp_v;
        bit   e_busy, e_done, e_vld, e_rd, e_wr;
        wl   = (s == 0) ? 1 : s;
        last = wr ? s + 4 : s + 3;
        @(negedge clk);
        req_start = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        for (int k = 1; k <= last; k++) begin
            @(negedge clk);
            if (k == 1) req_start = 1'b0;
            if (k == 2 && inj_req) begin
                req_start = 1'b1;
                req_write = ~wr;
                req_addr  = 16'hDEAD;
                req_wdata = 8'hEE;
            end
            if (k == 3) req_start = 1'b0;
            if (k == 2 && inj_cfg >= 0) begin
                cfg_we      = 1'b1;
                cfg_stretch = inj_cfg[2:0];
            end
            if (k == 3) cfg_we = 1'b0;
            if (wr) begin
                e_vld  = (k <= s + 2);
                e_rd   = 1'b0;
                e_wr   = (k >= 2) && (k <= 1 + wl);
                e_done = (k == s + 3);
                e_busy = (k <= s + 3);
            end else begin
                e_vld  = (k <= s + 1);
                e_rd   = e_vld;
                e_wr   = 1'b0;
                e_done = (k == s + 2);
                e_busy = (k <= s + 2);
            end
            act_v = {busy, done, mem_addr_vld, mem_rd, mem_wr};
            exp_v = {e_busy, e_done, e_vld, e_rd, e_wr};
            if (wr) chk(act_v == exp_v, "R5 R6 R7 R8 waveform {busy,done,vld,rd,wr}", act_v, exp_v);
            else    chk(act_v == exp_v, "R3 R7 R8 waveform {busy,done,vld,rd,wr}", act_v, exp_v);
            chk(!(mem_rd && mem_wr) && ((!mem_rd && !mem_wr) || mem_addr_vld),
                "R10 strobe exclusion", {mem_rd, mem_wr, mem_addr_vld}, 0);
            if (mem_addr_vld) chk(mem_addr == a, "R3 R5 address", mem_addr, a);
            if (mem_wr) chk(mem_wdata == d, "R5 write data", mem_wdata, d);
            if (!wr && k == s + 2) begin
                last_rd = model(a) ^ 8'(s);
                chk(rd_data == last_rd, "R4 read capture", rd_data, last_rd);
            end
        end
        if (wr) chk(rd_data == last_rd, "R4 rd_data kept over write", rd_data, last_rd);
    endtask

    initial begin
        rst_n       = 1'b0;
        cfg_we      = 1'b0;
        cfg_stretch = 3'd0;
        req_start   = 1'b0;
        req_write   = 1'b0;
        req_addr    = 16'h0;
        req_wdata   = 8'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, mem_addr_vld, mem_rd, mem_wr} == 5'b0, "R1 idle after reset",
            {busy, done, mem_addr_vld, mem_rd, mem_wr}, 0);
        chk(rd_data == 8'h00, "R1 rd_data after reset", rd_data, 0);
        // R1: default stretch of 1 before any register write
        run_access(1'b0, 16'h1234, 8'h00, 1, -1, 1'b0);
        run_access(1'b1, 16'h4321, 8'hA5, 1, -1, 1'b0);

        // R2: sweep every stretch value in both directions
        for (int s = 0; s < 8; s++) begin
            cfg_write(s);
            run_access(1'b0, 16'(16'h0F00 + s * 16'h0111), 8'h00, s, -1, 1'b0);
            run_access(1'b1, 16'(16'h8000 + s * 16'h0203), 8'(8'h5A + s), s, -1, 1'b0);
            run_access(1'b0, 16'(16'hC3C3 ^ s), 8'h00, s, -1, 1'b0);
            run_access(1'b1, 16'(16'h00FF + s), 8'(8'hC0 | s), s, -1, 1'b0);
        end

        // R8: stray requests while busy are dropped
        run_access(1'b0, 16'h2468, 8'h00, 7, -1, 1'b1);
        run_access(1'b1, 16'h1357, 8'h77, 7, -1, 1'b1);

        // R9: register write mid-access applies to the next access only
        run_access(1'b0, 16'hABCD, 8'h00, 7, 2, 1'b0);
        run_access(1'b0, 16'hBCDE, 8'h00, 2, -1, 1'b0);
        run_access(1'b1, 16'h0101, 8'h3E, 2, 0, 1'b0);
        run_access(1'b1, 16'h0202, 8'h3F, 0, -1, 1'b0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule